// File: doc/BRIEF.md
# LCD Frame Timing and Mode Controller

This block is the control core of a small matrix LCD driver. It keeps a handful of control fields written over a plain parallel write strobe: three display control bits, a frame-rate code, an oscillator trim code and a charge-pump multiplier code. From the control bits it decodes one of five display states. From the frame-rate code it picks one of eight uneven division ratios and divides the oscillator clock (the block's `clk`) into a one-cycle frame-start pulse. It also drives the enables for the oscillator and the high-voltage generator, a blanking flag that tells the column and row stages to hold their outputs low, the charge-pump factor and the raw trim code.

A two-state sequencer runs the frame divider. In `SEQ_COUNT` the counter advances every cycle (transition *advance*). When it reaches the latched period minus one it returns to zero and pulses `frame_start` (transition *wrap*). When the control bits request power-down it moves to `SEQ_HALT` (transition *sleep*): the counter is held at zero and no pulses come out. When power-down is released it returns to `SEQ_COUNT` and pulses `frame_start` at once (transition *wake*), so a fresh frame starts from count zero. A reset enters `SEQ_COUNT` with the count at zero (transition *reset entry*). The frame period and the displayed mode are latched only on a frame-start cycle, so a change written mid-frame cannot tear the current frame. Power-down entry is the one exception: it is taken at once.

Reset comes from the active-low `rst_n` pin (asynchronous) or from the `cmd_reset` strobe (synchronous). Both return every control field and the sequencer to their defaults.

Top module: `lcd_frame_ctrl`

## Requirements
- R1: After either reset, the control bits read as 000 and the display mode is OFF. The frame-rate code is 001, `trim_out` is 3'b110, `pump_factor` is 4 and `frame_start` is 0.
- R2: A write with `wr_en`=1 updates one field, chosen by `wr_addr`: 0 is the control bits (wr_data[0] enable, [1] full-on, [2] invert), 1 is the rate code [2:0], 2 is the trim [2:0] and 3 is the pump code [1:0]. From the cycle after the write, `trim_out` equals the trim field and `pump_factor` equals 4 + the pump code (codes 0..3 give 4, 5, 6, 7).
- R3: While counting, `frame_start` is high for exactly one cycle per period. The period is the ratio for the latched code, divided by RATIO_DIV. The ratios for codes 0 to 7 are, in order: 2448, 3265, 4082, 4896, 5714, 7340, 8968, 11428.
- R4: A new rate code does not alter the frame in progress. The interval ending at the next pulse keeps the old period, and the new period applies from that pulse on.
- R5: The requested mode is decoded from the control bits. Enable=0 with full-on=0 gives OFF. Enable=0 with full-on=1 gives POWER-DOWN. Enable=1 with full-on=0 gives NORMAL when invert=0 and INVERSE when invert=1. Enable=1 with full-on=1 gives ALL-ON.
- R6: When the full-on bit is set, the invert bit has no effect on the decoded mode.
- R7: `mode_onehot` is always one-hot (bit 0 OFF, bit 1 POWER-DOWN, bit 2 NORMAL, bit 3 INVERSE, bit 4 ALL-ON). It changes only on a cycle where `frame_start` is high, on entry to power-down, or on a reset.
- R8: In the OFF mode, `blank` is 1 while `osc_en` and `hv_en` stay 1. In the NORMAL, INVERSE and ALL-ON modes, `blank` is 0 and both enables are 1.
- R9: One cycle after the control field requests power-down, `mode_onehot` shows POWER-DOWN, `blank` is 1, and `osc_en` and `hv_en` are 0. While the power-down request stays, no `frame_start` pulse occurs.
- R10: One cycle after power-down is released, `frame_start` pulses and the newly requested mode shows. The next pulse then follows one full period later.
- R11: A `cmd_reset` strobe has the same effect as the reset pin. It wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; the frame divider counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | Synchronous reset command strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Field select for the write |
| wr_data | input | 3 | Write data |
| frame_start | output | 1 | One-cycle pulse at each frame boundary |
| mode_onehot | output | 5 | Displayed mode, one-hot, updated on frame boundaries |
| blank | output | 1 | Row and column outputs must be held low |
| osc_en | output | 1 | Oscillator enable |
| hv_en | output | 1 | High-voltage generator enable |
| pump_factor | output | 3 | Charge-pump multiplication factor (4 to 7) |
| trim_out | output | 3 | Oscillator trim code, passed through |

## Verification
The bench builds the block with RATIO_DIV = 8, which turns the eight frame periods into 306 to 1428 cycles. With periods that short, every rate code can be measured over several frames. Periods that straddle a rate change, and long power-down stretches, also fit in a short run. Each period the bench expects is the full ratio divided by 8, so the ratio mapping and the divider arithmetic are both checked at every code.

// File: rtl/lcd_frame_pkg.sv
package lcd_frame_pkg;

    localparam int unsigned RATE_W    = 3;
    localparam int unsigned TRIM_W    = 3;
    localparam int unsigned PUMP_W    = 2;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned WDATA_W   = 3;
    localparam int unsigned MODE_W    = 5;
    localparam int unsigned RATIO_MAX_BASE = 11428;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_RATE = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_TRIM = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_PUMP = 2'd3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 5'b00001,
        MODE_PDN  = 5'b00010,
        MODE_NORM = 5'b00100,
        MODE_INV  = 5'b01000,
        MODE_ALL  = 5'b10000
    } disp_mode_e;

    typedef enum logic {
        SEQ_HALT  = 1'b0,
        SEQ_COUNT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic inv;
        logic full;
        logic en;
    } disp_ctrl_t;

    function automatic int unsigned base_ratio(input logic [RATE_W-1:0] code);
        int unsigned r;
        unique case (code)
            3'd0: r = 2448;
            3'd1: r = 3265;
            3'd2: r = 4082;
            3'd3: r = 4896;
            3'd4: r = 5714;
            3'd5: r = 7340;
            3'd6: r = 8968;
            default: r = 11428;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcd_ctl_regs.sv
module lcd_ctl_regs
    import lcd_frame_pkg::*;
#(
    parameter logic [RATE_W-1:0] RATE_RST = 3'b001,
    parameter logic [TRIM_W-1:0] TRIM_RST = 3'b110,
    parameter logic [PUMP_W-1:0] PUMP_RST = 2'b00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    output disp_ctrl_t         ctrl_q,
    output logic [RATE_W-1:0]  rate_q,
    output logic [TRIM_W-1:0]  trim_q,
    output logic [PUMP_W-1:0]  pump_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rate_q <= RATE_RST;
            trim_q <= TRIM_RST;
            pump_q <= PUMP_RST;
        end else if (soft_rst) begin
            ctrl_q <= '0;
            rate_q <= RATE_RST;
            trim_q <= TRIM_RST;
            pump_q <= PUMP_RST;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL: ctrl_q <= disp_ctrl_t'(wr_data);
                ADR_RATE: rate_q <= wr_data[RATE_W-1:0];
                ADR_TRIM: trim_q <= wr_data[TRIM_W-1:0];
                default:  pump_q <= wr_data[PUMP_W-1:0];
            endcase
        end
    end

endmodule

// File: rtl/lcd_mode_decode.sv
module lcd_mode_decode
    import lcd_frame_pkg::*;
(
    input  disp_ctrl_t ctrl,
    output disp_mode_e req_mode,
    output logic       req_pdn
);

    always_comb begin
        unique case ({ctrl.en, ctrl.full})
            2'b00:   req_mode = MODE_OFF;
            2'b01:   req_mode = MODE_PDN;
            2'b10:   req_mode = ctrl.inv ? MODE_INV : MODE_NORM;
            default: req_mode = MODE_ALL;
        endcase
    end

    assign req_pdn = (req_mode == MODE_PDN);

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_frame_pkg::*;
#(
    parameter int unsigned       RATIO_DIV = 1,
    parameter logic [RATE_W-1:0] RATE_RST  = 3'b001,
    localparam int unsigned      MAX_PER   = RATIO_MAX_BASE / RATIO_DIV,
    localparam int unsigned      CNT_W     = $clog2(MAX_PER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [RATE_W-1:0] rate_code,
    input  disp_mode_e        req_mode,
    input  logic              req_pdn,
    output logic              frame_start,
    output disp_mode_e        mode_q
);

    localparam logic [CNT_W-1:0] RST_PER = CNT_W'(base_ratio(RATE_RST) / RATIO_DIV);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] per_q, per_d;
    logic [CNT_W-1:0] new_per;
    disp_mode_e       mode_d;
    logic             fs_d;

    assign new_per = CNT_W'(base_ratio(rate_code) / RATIO_DIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_COUNT;
        end else if (soft_rst) begin
            state_q <= SEQ_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        per_d   = per_q;
        mode_d  = mode_q;
        fs_d    = 1'b0;
        unique case (state_q)
            SEQ_HALT: begin
                if (!req_pdn) begin
                    state_d = SEQ_COUNT;
                    cnt_d   = '0;
                    per_d   = new_per;
                    mode_d  = req_mode;
                    fs_d    = 1'b1;
                end
            end
            SEQ_COUNT: begin
                if (req_pdn) begin
                    state_d = SEQ_HALT;
                    cnt_d   = '0;
                    mode_d  = MODE_PDN;
                end else if (cnt_q == per_q - 1'b1) begin
                    cnt_d  = '0;
                    per_d  = new_per;
                    mode_d = req_mode;
                    fs_d   = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = SEQ_COUNT;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            per_q       <= RST_PER;
            mode_q      <= MODE_OFF;
            frame_start <= 1'b0;
        end else if (soft_rst) begin
            cnt_q       <= '0;
            per_q       <= RST_PER;
            mode_q      <= MODE_OFF;
            frame_start <= 1'b0;
        end else begin
            cnt_q       <= cnt_d;
            per_q       <= per_d;
            mode_q      <= mode_d;
            frame_start <= fs_d;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !frame_start); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < per_q); // R4
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == SEQ_HALT) |-> (!frame_start && cnt_q == '0)); // R9
    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(mode_q) == 1); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(mode_q) |-> (frame_start || mode_q == MODE_PDN || $past(soft_rst))); // R7

endmodule

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
    import lcd_frame_pkg::*;
#(
    parameter int unsigned       RATIO_DIV  = 1,
    parameter int unsigned       PUMP_BASE  = 4,
    parameter logic [RATE_W-1:0] RATE_RST   = 3'b001,
    parameter logic [TRIM_W-1:0] TRIM_RST   = 3'b110,
    parameter logic [PUMP_W-1:0] PUMP_RST   = 2'b00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_reset,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [2:0]  wr_data,
    output logic        frame_start,
    output logic [4:0]  mode_onehot,
    output logic        blank,
    output logic        osc_en,
    output logic        hv_en,
    output logic [2:0]  pump_factor,
    output logic [2:0]  trim_out
);

    disp_ctrl_t        ctrl_q;
    logic [RATE_W-1:0] rate_q;
    logic [TRIM_W-1:0] trim_q;
    logic [PUMP_W-1:0] pump_q;
    disp_mode_e        req_mode;
    logic              req_pdn;
    disp_mode_e        mode_q;

    lcd_ctl_regs #(
        .RATE_RST (RATE_RST),
        .TRIM_RST (TRIM_RST),
        .PUMP_RST (PUMP_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (cmd_reset),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl_q   (ctrl_q),
        .rate_q   (rate_q),
        .trim_q   (trim_q),
        .pump_q   (pump_q)
    );

    lcd_mode_decode u_decode (
        .ctrl     (ctrl_q),
        .req_mode (req_mode),
        .req_pdn  (req_pdn)
    );

    lcd_frame_seq #(
        .RATIO_DIV (RATIO_DIV),
        .RATE_RST  (RATE_RST)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (cmd_reset),
        .rate_code   (rate_q),
        .req_mode    (req_mode),
        .req_pdn     (req_pdn),
        .frame_start (frame_start),
        .mode_q      (mode_q)
    );

    always_comb begin
        mode_onehot = mode_q;
        blank       = (mode_q == MODE_OFF) || (mode_q == MODE_PDN);
        osc_en      = (mode_q != MODE_PDN);
        hv_en       = (mode_q != MODE_PDN);
        pump_factor = 3'(PUMP_BASE) + {1'b0, pump_q};
        trim_out    = trim_q;
    end

    AST_PDN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) ($past(req_pdn) && !$past(cmd_reset)) |-> (mode_q == MODE_PDN && !osc_en && !hv_en)); // R9
    AST_FULL_WINS: assert property (@(posedge clk) disable iff (!rst_n) (frame_start && $past(ctrl_q.en && ctrl_q.full && !cmd_reset)) |-> (mode_q == MODE_ALL)); // R6

endmodule

// File: tb/lcd_frame_ctrl_bench.sv
module lcd_frame_ctrl_bench;

    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_reset;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [2:0] wr_data;
    logic       frame_start;
    logic [4:0] mode_onehot;
    logic       blank, osc_en, hv_en;
    logic [2:0] pump_factor, trim_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    lcd_frame_ctrl #(.RATIO_DIV(DIV)) u_lcd_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .frame_start(frame_start),
        .mode_onehot(mode_onehot), .blank(blank), .osc_en(osc_en), .hv_en(hv_en),
        .pump_factor(pump_factor), .trim_out(trim_out)
    );

    // Mode indices: 0 OFF, 1 POWER-DOWN, 2 NORMAL, 3 INVERSE, 4 ALL-ON
    function automatic int ref_period(input int code);
        int r;
        case (code)
            0: r = 2448;  1: r = 3265;  2: r = 4082;  3: r = 4896;
            4: r = 5714;  5: r = 7340;  6: r = 8968;  default: r = 11428;
        endcase
        return r / DIV;
    endfunction

    function automatic int ref_mode(input int en, input int full, input int inv);
        if (en == 0) return (full != 0) ? 1 : 0;
        if (full != 0) return 4;
        return (inv != 0) ? 3 : 2;
    endfunction

    // Behavioural reference model
    int m_en, m_full, m_inv, m_rate, m_trim, m_pump;
    int m_phase, m_period, m_mode;
    bit m_sleep, m_fs;

    always @(posedge clk) begin
        int want;
        if (!rst_n || cmd_reset) begin
            m_en = 0; m_full = 0; m_inv = 0; m_rate = 1; m_trim = 6; m_pump = 0;
            m_phase = 0; m_period = ref_period(1); m_mode = 0; m_sleep = 0; m_fs = 0;
        end else begin
            want = ref_mode(m_en, m_full, m_inv);
            m_fs = 0;
            if (m_sleep) begin
                if (want != 1) begin
                    m_sleep = 0; m_phase = 0; m_period = ref_period(m_rate);
                    m_mode = want; m_fs = 1;
                end
            end else if (want == 1) begin
                m_sleep = 1; m_phase = 0; m_mode = 1;
            end else if (m_phase + 1 >= m_period) begin
                m_phase = 0; m_period = ref_period(m_rate); m_mode = want; m_fs = 1;
            end else begin
                m_phase = m_phase + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_en = wr_data[0]; m_full = wr_data[1]; m_inv = wr_data[2]; end
                    2'd1: m_rate = wr_data;
                    2'd2: m_trim = wr_data;
                    default: m_pump = wr_data[1:0];
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(frame_start == m_fs, "R3 frame_start vs model", frame_start, m_fs);
            chk(mode_onehot == 5'(1 << m_mode), "R5 mode vs model", mode_onehot, 1 << m_mode);
            chk(blank == (m_mode <= 1), "R8 blank vs model", blank, m_mode <= 1);
            chk(osc_en == (m_mode != 1), "R9 osc_en vs model", osc_en, m_mode != 1);
            chk(hv_en == (m_mode != 1), "R9 hv_en vs model", hv_en, m_mode != 1);
            chk(pump_factor == 3'(4 + m_pump), "R2 pump vs model", pump_factor, 4 + m_pump);
            chk(trim_out == 3'(m_trim), "R2 trim vs model", trim_out, m_trim);
        end
    end

    task automatic wr(input int a, input int d);
        wr_addr = 2'(a); wr_data = 3'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_fs();
        do @(negedge clk); while (!frame_start);
    endtask

    task automatic cycles_to_fs(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!frame_start && n < 20000);
    endtask

    initial begin
        int n;
        rst_n = 1'b0; cmd_reset = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mode_onehot == 5'b00001, "R1 reset mode OFF", mode_onehot, 1);
        chk(trim_out == 3'b110, "R1 reset trim", trim_out, 6);
        chk(pump_factor == 3'd4, "R1 reset pump", pump_factor, 4);
        chk(frame_start == 1'b0, "R1 reset frame_start", frame_start, 0);
        wait_fs();
        cycles_to_fs(n);
        chk(n == ref_period(1), "R1 default rate period", n, ref_period(1));

        // R2 trim and pump fields
        wr(2, 3); chk(trim_out == 3'd3, "R2 trim write", trim_out, 3);
        for (int p = 0; p < 4; p++) begin
            wr(3, p); chk(pump_factor == 3'(4 + p), "R2 pump write", pump_factor, 4 + p);
        end

        // R3 every rate code
        for (int c = 0; c < 8; c++) begin
            wr(1, c);
            wait_fs();
            cycles_to_fs(n);
            chk(n == ref_period(c), "R3 period for code", n, ref_period(c));
        end

        // R4 change mid-frame keeps old period once
        wr(1, 2);
        wait_fs();
        wr(1, 6);
        cycles_to_fs(n);
        n = n + 1;
        chk(n == ref_period(2), "R4 old period kept", n, ref_period(2));
        cycles_to_fs(n);
        chk(n == ref_period(6), "R4 new period applied", n, ref_period(6));
        wr(1, 0);

        // R5 / R7 / R8 modes
        wait_fs();
        chk(mode_onehot == 5'b00001 && blank && osc_en && hv_en, "R8 off keeps power", mode_onehot, 1);
        wr(0, 3'b001);
        chk(mode_onehot == 5'b00001, "R7 no change mid-frame", mode_onehot, 1);
        wait_fs();
        chk(mode_onehot == 5'b00100 && !blank, "R5 normal", mode_onehot, 4);
        wr(0, 3'b101);
        chk(mode_onehot == 5'b00100, "R7 hold before boundary", mode_onehot, 4);
        wait_fs();
        chk(mode_onehot == 5'b01000, "R5 inverse", mode_onehot, 8);
        wr(0, 3'b111);
        wait_fs();
        chk(mode_onehot == 5'b10000, "R6 full wins over invert", mode_onehot, 16);
        wr(0, 3'b011);
        wait_fs();
        chk(mode_onehot == 5'b10000, "R6 full wins, invert clear", mode_onehot, 16);

        // R9 power-down
        repeat (7) @(negedge clk);
        wr(0, 3'b110);
        @(negedge clk);
        chk(mode_onehot == 5'b00010, "R9 pdn mode", mode_onehot, 2);
        chk(!osc_en && !hv_en && blank, "R9 pdn enables", {osc_en, hv_en}, 0);
        n = 0;
        for (int i = 0; i < 3000; i++) begin @(negedge clk); if (frame_start) n++; end
        chk(n == 0, "R9 no pulses in power-down", n, 0);

        // R10 wake
        wr(0, 3'b001);
        @(negedge clk);
        chk(frame_start == 1'b1, "R10 pulse on wake", frame_start, 1);
        chk(mode_onehot == 5'b00100, "R10 mode on wake", mode_onehot, 4);
        cycles_to_fs(n);
        chk(n == ref_period(0), "R10 full period after wake", n, ref_period(0));

        // R11 reset command, priority over write
        wr(1, 5); wr(3, 3); wr(2, 1);
        wr_addr = 2'd2; wr_data = 3'd0; wr_en = 1'b1; cmd_reset = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cmd_reset = 1'b0;
        chk(trim_out == 3'b110, "R11 trim default, write lost", trim_out, 6);
        chk(pump_factor == 3'd4, "R11 pump default", pump_factor, 4);
        chk(mode_onehot == 5'b00001, "R11 mode OFF", mode_onehot, 1);
        wait_fs();
        cycles_to_fs(n);
        chk(n == ref_period(1), "R11 default rate restored", n, ref_period(1));

        repeat (5) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule